// File: doc/BRIEF.md
# Pipelined Adder-Tree Multiplier

This block multiplies two unsigned operands of equal width (32 bits by default) and returns the full double-width product. Each bit of the multiplier selects a copy of the multiplicand, which is moved left by that bit's position to form one row. The rows are then added pairwise in a balanced binary tree. The tree needs log2 of the operand width levels (five for 32 bits), compared with one addition per multiplier bit in a sequential design.

A register bank sits after every tree level, so the block accepts a new operand pair on every clock and holds one multiply in each level at once. A qualifier bit travels through the same register stages as the data. A consumer therefore needs only to watch the output qualifier to know which product words are meaningful.

Top module: `pipe_tree_mult`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the exact unsigned product of the operand pair it belongs to, all 64 bits, with no carry lost (for example 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001).
- R2: An operand pair presented with `in_valid` high before rising edge k appears on the outputs after rising edge k+4: five register stages, one per tree level.
- R3: Pairs presented on consecutive cycles yield products on consecutive cycles, in the same order, with no stall.
- R4: A cycle with `in_valid` low yields a cycle with `out_valid` low exactly five edges later, and a single valid input yields exactly one valid output cycle.
- R5: A synchronous active-high `rst` drives `out_valid` low on the edge it is sampled and clears every in-flight qualifier, so no operand accepted before reset reaches the output.
- R6: Row i of the tree is the multiplicand gated by multiplier bit i and placed i bits to the left, so a multiplier with only bit i set returns the multiplicand shifted left by i.
- R7: A zero in either operand gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the operand pair on this cycle |
| in_a | input | 32 | Multiplicand, unsigned |
| in_b | input | 32 | Multiplier, unsigned |
| out_valid | output | 1 | Qualifies `out_product`, registered |
| out_product | output | 64 | Full unsigned product, registered |

## Verification
Every product and every qualifier is due five rising edges after the edge that samples its operands. A reset clears the pipeline on the edge it is sampled and keeps the qualifier low until five fresh edges have passed. The bench pushes each sampled input pair into a queue on every rising edge and keeps exactly five entries. On every falling edge it compares the outputs with the oldest entry, and while the queue is not yet full it expects the qualifier to be low. One separate test counts falling edges from a single valid pulse to its result and requires the result on the fifth edge, once only.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  // Number of pairwise addition levels needed to reduce n rows to one.
  function automatic int tree_depth(input int n);
    return $clog2(n);
  endfunction

  // Number of leaf rows after padding n up to a power of two.
  function automatic int tree_leaves(input int n);
    return 1 << $clog2(n);
  endfunction

  // Entry offset of level l inside a flat vector holding all tree levels,
  // level 0 (the leaves) first, each level half the size of the one before.
  function automatic int level_offset(input int leaves, input int l);
    return 2 * leaves - 2 * (leaves >> l);
  endfunction

endpackage

// File: rtl/ptm_ppgen.sv
module ptm_ppgen #(
  parameter int OP_W   = 32,
  parameter int LEAVES = 32,
  parameter int PW     = 2 * OP_W
) (
  input  logic [OP_W-1:0]        mcand,
  input  logic [OP_W-1:0]        mplier,
  output logic [LEAVES*PW-1:0]   rows
);

  // One row per multiplier bit: multiplicand gated by that bit, moved left
  // by the bit's weight. Padding rows beyond OP_W are zero.
  for (genvar i = 0; i < LEAVES; i++) begin : g_row
    if (i < OP_W) begin : g_live
      logic [PW-1:0] gated;
      assign gated = {{(PW-OP_W){1'b0}}, mcand & {OP_W{mplier[i]}}};
      assign rows[i*PW +: PW] = gated << i;
    end else begin : g_pad
      assign rows[i*PW +: PW] = '0;
    end
  end

endmodule

// File: rtl/ptm_level.sv
module ptm_level #(
  parameter int PW   = 64,
  parameter int N_IN = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_v,
  input  logic [N_IN*PW-1:0]       terms,
  output logic                     out_v,
  output logic [(N_IN/2)*PW-1:0]   sums
);

  localparam int N_OUT = N_IN / 2;

  logic [N_OUT*PW-1:0] sum_nxt;

  // Pairwise adders; full PW width so no carry can be dropped.
  for (genvar k = 0; k < N_OUT; k++) begin : g_pair
    assign sum_nxt[k*PW +: PW] = terms[(2*k)*PW +: PW] + terms[(2*k+1)*PW +: PW];
  end

  // Data bank without reset (fabric-friendly), qualifier with reset.
  always_ff @(posedge clk) begin
    sums <= sum_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
  end

endmodule

// File: rtl/pipe_tree_mult.sv
module pipe_tree_mult #(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  output logic [2*OP_W-1:0] out_product
);

  import ptm_pkg::*;

  localparam int PW      = 2 * OP_W;
  localparam int LEAVES  = tree_leaves(OP_W);
  localparam int LEVELS  = tree_depth(OP_W);
  localparam int ENTRIES = 2 * LEAVES - 1;

  // All tree levels packed into one vector; each slice has a single driver.
  wire [ENTRIES*PW-1:0] node;
  wire [LEVELS:0]       vchain;

  assign vchain[0] = in_valid;

  ptm_ppgen #(
    .OP_W   (OP_W),
    .LEAVES (LEAVES),
    .PW     (PW)
  ) u_ppgen (
    .mcand  (in_a),
    .mplier (in_b),
    .rows   (node[0 +: LEAVES*PW])
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int N_IN    = LEAVES >> l;
    localparam int OFF_IN  = level_offset(LEAVES, l);
    localparam int OFF_OUT = level_offset(LEAVES, l + 1);

    ptm_level #(
      .PW   (PW),
      .N_IN (N_IN)
    ) u_level (
      .clk   (clk),
      .rst   (rst),
      .in_v  (vchain[l]),
      .terms (node[OFF_IN*PW +: N_IN*PW]),
      .out_v (vchain[l+1]),
      .sums  (node[OFF_OUT*PW +: (N_IN/2)*PW])
    );
  end

  assign out_valid   = vchain[LEVELS];
  assign out_product = node[level_offset(LEAVES, LEVELS)*PW +: PW];

endmodule

module ptm_checker #(
  parameter int OP_W = 32,
  parameter int LAT  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_a,
  input logic [OP_W-1:0]   in_b,
  input logic              out_valid,
  input logic [2*OP_W-1:0] out_product
);

  localparam int PW = 2 * OP_W;

  logic [LAT-1:0] v_sr;
  logic [PW-1:0]  p_sr [LAT];

  always_ff @(posedge clk) begin
    if (rst) v_sr <= '0;
    else     v_sr <= {v_sr[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    p_sr[0] <= PW'(in_a) * PW'(in_b);
    for (int s = 1; s < LAT; s++) p_sr[s] <= p_sr[s-1];
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sr[LAT-1]);

  assert_product_exact_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_product == p_sr[LAT-1]);

  assert_bubble_kept_R4: assert property (@(posedge clk) disable iff (rst)
    !v_sr[LAT-1] |-> !out_valid);

  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

endmodule

bind pipe_tree_mult ptm_checker #(.OP_W(OP_W), .LAT(LEVELS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_product (out_product)
);

// File: tb/pipe_tree_mult_bench.sv
`timescale 1ns/1ps
module pipe_tree_mult_bench;

  localparam int W   = 32;
  localparam int PW  = 64;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  wire           out_valid;
  wire [PW-1:0]  out_product;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag   = "R1";

  typedef struct packed {
    logic          v;
    logic [PW-1:0] p;
  } exp_t;
  exp_t q[$];

  pipe_tree_mult #(.OP_W(W)) u_pipe_tree_mult (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_a        (a),
    .in_b        (b),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string r, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // Reference model: what was sampled on each edge, kept for LAT edges.
  always @(posedge clk) begin
    if (rst) q.delete();
    else begin
      exp_t e;
      e.v = in_valid;
      e.p = PW'(a) * PW'(b);
      q.push_back(e);
      if (q.size() > LAT) void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() < LAT) begin
        check("R5", PW'(out_valid), PW'(0));
      end else if (!q[0].v) begin
        check("R4", PW'(out_valid), PW'(0));
      end else begin
        check(tag, PW'(out_valid), PW'(1));
        check(tag, out_product, q[0].p);
      end
    end
  end

  task automatic send(input bit v, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    in_valid = v;
    a = x;
    b = y;
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 2; i++) send(1'b0, $urandom, $urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5", PW'(out_valid), PW'(0));
    rst = 1'b0;

    // R7: zero operands on either side
    tag = "R7";
    send(1'b1, 32'h0, 32'hFFFF_FFFF);
    send(1'b1, 32'hFFFF_FFFF, 32'h0);
    send(1'b1, 32'h0, 32'h0);
    flush();

    // R1: extremes, including the largest product
    tag = "R1";
    send(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send(1'b1, 32'h1, 32'h1);
    send(1'b1, 32'h8000_0000, 32'h8000_0000);
    send(1'b1, 32'h1234_5678, 32'h9ABC_DEF0);
    flush();

    // R6: single-bit multipliers select one shifted row
    tag = "R6";
    for (int i = 0; i < W; i++) send(1'b1, 32'h9E37_79B9, 32'h1 << i);
    flush();

    // R2 and R4: one pulse arrives on the fifth edge, once
    begin
      int first_seen = 0;
      int seen_cnt   = 0;
      send(1'b1, 32'h0000_BEEF, 32'h0000_0101);
      for (int k = 1; k <= 10; k++) begin
        send(1'b0, 32'h0, 32'h0);
        if (out_valid) begin
          seen_cnt++;
          if (first_seen == 0) first_seen = k;
        end
      end
      check("R2", PW'(first_seen), PW'(LAT));
      check("R4", PW'(seen_cnt), PW'(1));
    end

    // R3: back-to-back stream
    tag = "R3";
    for (int i = 0; i < 300; i++) send(1'b1, $urandom, $urandom);
    flush();

    // R4: random bubbles between valid pairs
    tag = "R4";
    for (int i = 0; i < 2000; i++) send(1'($urandom % 2), $urandom, $urandom);
    flush();

    // R5: reset while the pipeline is full
    tag = "R5";
    for (int i = 0; i < LAT; i++) send(1'b1, $urandom, $urandom);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R5", PW'(out_valid), PW'(0));
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < LAT; i++) send(1'b0, 32'h0, 32'h0);
    tag = "R1";
    for (int i = 0; i < 200; i++) send(1'b1, $urandom, $urandom);
    flush();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule